// File: doc/BRIEF.md
# Registered-IO Pass-Through Synchronous SRAM

This block is a single-clock static memory with separate write-data and read-data buses. Every input is captured in an input register on the rising clock edge: address, write data, and the active-low chip-enable, write-enable and output-enable. The result of the cycle goes into an output register on the following rising edge. That result is either the array word (for a read) or the captured input word (for a pass-through). The output drivers are modelled as a data bus plus a drive flag.

Chip-enable never deselects the memory. It only gates writes into the array. Whenever a cycle is not a read, the captured input word is forwarded to the output register. Output-enable alone decides whether the outputs are driven.

A cycle whose inputs are applied before edge N shows its result on the outputs after edge N+1. The array holds 2^ADDR_W words of DATA_W bits, with 256 words of 9 bits by default.

Top module: `sram_pt_top`

## Requirements
- R1: Inputs are sampled only at the rising clock edge. Changes between edges have no effect, and the result of inputs applied before edge N is on `data_o`/`drive_o` after edge N+1.
- R2: With chip-enable low and write-enable high (a read), `data_o` carries the array word at the captured address.
- R3: With chip-enable and write-enable low and output-enable high (a normal write), the captured data is stored at the captured address.
- R4: With chip-enable, write-enable and output-enable all low (a transparent write), the data is stored and also appears on `data_o` with `drive_o` high.
- R5: With chip-enable high, write-enable low has no effect on the array, which a later read of that address shows.
- R6: With chip-enable high, the captured input data appears on `data_o`. It is driven whenever output-enable was captured low.
- R7: `drive_o` equals the inverse of the captured output-enable and is updated on the same edge as `data_o`. A captured high output-enable gives `drive_o` = 0 in every cycle type.
- R8: While `rst_ni` is low, all input registers take their inactive values (enables high, address and data 0), and `data_o` = 0 and `drive_o` = 0. The array contents survive a reset.
- R9: Any cycle that is not a read forwards the captured input word to `data_o`. This includes chip-enable high with write-enable high, and a normal write.
- R10: A read in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset of the registers |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write / pass-through data |
| ce_ni | input | 1 | Chip-enable, active low, gates array writes only |
| we_ni | input | 1 | Write-enable, active low |
| oe_ni | input | 1 | Output-enable, active low |
| data_o | output | DATA_W | Registered output word |
| drive_o | output | 1 | Output drive flag, 1 = bus driven, 0 = high impedance |

## Verification
The bench keeps an independent model of the array and of the two register stages, and compares both outputs on every clock.

It targets a write with chip-enable high: a design that let it through would corrupt the word that a later read returns. It also targets reads with output-enable high, where a design that tied the drive flag to chip-enable would drive a bus that should float.

Further cases are:
- a write followed at once by a read of the same address, which catches a stale-read path;
- junk pulses on the inputs between edges, which expose any unregistered path;
- a reset in mid-run followed by reads, which catches a reset that clears the array or leaves the outputs driven.

// File: rtl/sram_pt_pkg.sv
package sram_pt_pkg;
  typedef enum logic [1:0] {
    OP_PASS   = 2'd0,
    OP_READ   = 2'd1,
    OP_WRITE  = 2'd2,
    OP_TWRITE = 2'd3
  } sram_op_e;
endpackage

// File: rtl/sram_pt_in_reg.sv
module sram_pt_in_reg #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic [DATA_W-1:0] din_q_o,
  output logic              ce_n_q_o,
  output logic              we_n_q_o,
  output logic              oe_n_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o <= '0;
      din_q_o  <= '0;
      ce_n_q_o <= 1'b1;
      we_n_q_o <= 1'b1;
      oe_n_q_o <= 1'b1;
    end else begin
      addr_q_o <= addr_i;
      din_q_o  <= data_i;
      ce_n_q_o <= ce_ni;
      we_n_q_o <= we_ni;
      oe_n_q_o <= oe_ni;
    end
  end
endmodule

// File: rtl/sram_pt_ctrl.sv
module sram_pt_ctrl
  import sram_pt_pkg::*;
(
  input  logic     ce_n_i,
  input  logic     we_n_i,
  input  logic     oe_n_i,
  output sram_op_e op_o,
  output logic     wr_en_o
);
  // chip-enable only gates the array write; it never deselects
  always_comb begin
    if (ce_n_i)      op_o = OP_PASS;
    else if (we_n_i) op_o = OP_READ;
    else if (oe_n_i) op_o = OP_WRITE;
    else             op_o = OP_TWRITE;
  end

  assign wr_en_o = (op_o == OP_WRITE) || (op_o == OP_TWRITE);
endmodule

// File: rtl/sram_pt_array.sv
module sram_pt_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // no reset: contents survive rst_ni
  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/sram_pt_out_reg.sv
module sram_pt_out_reg
  import sram_pt_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  sram_op_e          op_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o
);
  logic [DATA_W-1:0] data_d;

  assign data_d = (op_i == OP_READ) ? rdata_i : din_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      drive_o <= 1'b0;
    end else begin
      data_o  <= data_d;
      drive_o <= ~oe_n_i;
    end
  end
endmodule

// File: rtl/sram_pt_top.sv
module sram_pt_top
  import sram_pt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              ce_n_q;
  logic              we_n_q;
  logic              oe_n_q;
  sram_op_e          op;
  logic              wr_en;
  logic [DATA_W-1:0] rdata;

  sram_pt_in_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_in (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .oe_ni    (oe_ni),
    .addr_q_o (addr_q),
    .din_q_o  (din_q),
    .ce_n_q_o (ce_n_q),
    .we_n_q_o (we_n_q),
    .oe_n_q_o (oe_n_q)
  );

  sram_pt_ctrl u_ctrl (
    .ce_n_i  (ce_n_q),
    .we_n_i  (we_n_q),
    .oe_n_i  (oe_n_q),
    .op_o    (op),
    .wr_en_o (wr_en)
  );

  sram_pt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i   (clk_i),
    .wr_en_i (wr_en),
    .addr_i  (addr_q),
    .wdata_i (din_q),
    .rdata_o (rdata)
  );

  sram_pt_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .oe_n_i  (oe_n_q),
    .rdata_i (rdata),
    .din_i   (din_q),
    .data_o  (data_o),
    .drive_o (drive_o)
  );
endmodule

// File: rtl/sram_pt_chk.sv
module sram_pt_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_n_q,
  input logic              we_n_q,
  input logic              oe_n_q,
  input logic [DATA_W-1:0] din_q,
  input logic [DATA_W-1:0] data_o,
  input logic              drive_o
);
  AST_DRIVE_FOLLOWS_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drive_o == !$past(oe_n_q))); // R7

  AST_CE_HIGH_PASSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_q |=> (data_o == $past(din_q))); // R6

  AST_TWRITE_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_q && !we_n_q && !oe_n_q) |=> (drive_o && data_o == $past(din_q))); // R4

  AST_NONREAD_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_n_q || !we_n_q) |=> (data_o == $past(din_q))); // R9

  AST_RESET_FLOATS: assert property (@(posedge clk_i)
    !rst_ni |-> (!drive_o && data_o == '0)); // R8
endmodule

bind sram_pt_top sram_pt_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ce_n_q  (ce_n_q),
  .we_n_q  (we_n_q),
  .oe_n_q  (oe_n_q),
  .din_q   (din_q),
  .data_o  (data_o),
  .drive_o (drive_o)
);

// File: tb/sram_pt_top_tb_top.sv
module sram_pt_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [DW-1:0] data_o;
  logic          drive_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_pt_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(din),
    .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .data_o(data_o), .drive_o(drive_o)
  );

  // behavioural reference: array plus two stages
  int    m_mem [DEPTH];
  int    s_ce, s_we, s_oe, s_addr, s_din;
  int    e_data, e_drive;
  string cur_tag = "R8", s_tag = "R8", e_tag = "R8";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ce = 1; s_we = 1; s_oe = 1; s_addr = 0; s_din = 0;
      e_data = 0; e_drive = 0; s_tag = "R8"; e_tag = "R8";
    end else begin
      if (s_ce == 0 && s_we == 0) m_mem[s_addr] = s_din;
      e_data  = (s_ce == 0 && s_we == 1) ? m_mem[s_addr] : s_din;
      e_drive = (s_oe == 0) ? 1 : 0;
      e_tag   = s_tag;
      s_ce = int'(ce_n); s_we = int'(we_n); s_oe = int'(oe_n);
      s_addr = int'(addr); s_din = int'(din); s_tag = cur_tag;
    end
  end

  task automatic compare();
    checks++;
    if (int'(data_o) != e_data || int'(drive_o) != e_drive) begin
      fails++;
      $display("FAIL %s t=%0t data=%0d drive=%0d expected data=%0d drive=%0d",
               e_tag, $time, data_o, drive_o, e_data, e_drive);
    end
  endtask

  task automatic step(string tag, logic c, logic w, logic o, int a, int d);
    @(negedge clk);
    compare();
    cur_tag = tag;
    ce_n = c; we_n = w; oe_n = o; addr = AW'(a); din = DW'(d);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    int lfsr = 32'h1d3;
    // R8: reset state, enables driven active during reset must not leak
    ce_n = 0; we_n = 0; oe_n = 0; din = 9'h1ab;
    repeat (3) begin
      @(negedge clk);
      compare();
    end
    rst_n = 1'b1;
    // R3: normal writes fill the array, outputs float, data forwarded (R9)
    for (int i = 0; i < DEPTH; i++) step("R3", 0, 0, 1, i, (i * 7 + 3) % 512);
    // R2: reads, driven
    for (int i = 0; i < 40; i++) begin
      lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
      step("R2", 0, 1, 0, lfsr % DEPTH, 0);
    end
    // R4: transparent writes then readback
    for (int i = 0; i < 16; i++) step("R4", 0, 0, 0, i * 5, 511 - i * 3);
    for (int i = 0; i < 16; i++) step("R4", 0, 1, 0, i * 5, 0);
    // R5/R6: write attempts with chip-enable high, then readback unchanged
    for (int i = 0; i < 16; i++) step("R5", 1, 0, 0, 200 + i, 85 + i);
    for (int i = 0; i < 16; i++) step("R5", 0, 1, 0, 200 + i, 0);
    step("R6", 1, 0, 1, 3, 300);
    // R9: chip-enable high, write-enable high is pass-through
    for (int i = 0; i < 8; i++) step("R9", 1, 1, i % 2, i, 256 + i * 11);
    // R7: output-enable high floats reads and pass-through
    for (int i = 0; i < 8; i++) step("R7", 0, 1, 1, i * 9, 0);
    step("R7", 1, 1, 1, 0, 77);
    // R10: write then immediate read of same address
    for (int i = 0; i < 8; i++) begin
      step("R10", 0, 0, 1, 100 + i, 400 - i);
      step("R10", 0, 1, 0, 100 + i, 0);
    end
    // R1: junk pulses between edges must not be sampled
    for (int i = 0; i < 8; i++) begin
      step("R1", 0, (i % 2 == 0) ? 1'b0 : 1'b1, 0, 30 + i, 123 + i);
      #1;
      begin
        logic sc, sw, so; logic [AW-1:0] sa; logic [DW-1:0] sd;
        sc = ce_n; sw = we_n; so = oe_n; sa = addr; sd = din;
        ce_n = ~sc; we_n = ~sw; oe_n = ~so; addr = ~sa; din = ~sd;
        #2;
        ce_n = sc; we_n = sw; oe_n = so; addr = sa; din = sd;
      end
    end
    for (int i = 0; i < 8; i++) step("R1", 0, 1, 0, 30 + i, 0);
    // R8: reset mid-run, array retained
    step("R8", 0, 1, 0, 0, 0);
    @(negedge clk);
    compare();
    rst_n = 1'b0;
    #1;
    compare();
    @(negedge clk);
    compare();
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) step("R8", 0, 1, 0, i * 13, 0);
    step("R8", 1, 1, 1, 0, 0);
    step("R8", 1, 1, 1, 0, 0);
    @(negedge clk);
    compare();
    done = 1'b1;
    report();
    $finish;
  end
endmodule